// File: doc/BRIEF.md
# Stack Address Counter

This block keeps the top-of-stack index for a small hardware stack and turns it into the address that a stack memory needs for the next access. A push writes at the slot the index currently names and then moves the index up by one. A pop reads the slot just below the index and leaves the index one lower. The memory port can therefore take the address straight from this block in the same cycle that the operation is requested.

The address output is a combinational choice between the index and the index minus one, driven by the direction input. A pop's read address is ready before the clock edge that commits the pop. The index register has an asynchronous clear. It moves only on a rising clock edge with the step enable high.

Two flags report empty and full. The top slot is held in reserve, so the stack counts as full one entry early. A push into a full stack or a pop from an empty stack leaves the index where it is and produces a one-cycle fault pulse.

Top module: `stack_addr_gen`

## Requirements
- R1: While `clr` is high, `ptr` is 0 and `fault` is 0, with no clock edge needed.
- R2: A rising edge with `step_en`=1, `push_dir`=1 and `full`=0 raises `ptr` by one.
- R3: A rising edge with `step_en`=1, `push_dir`=0 and `empty`=0 lowers `ptr` by one.
- R4: A rising edge with `step_en`=0 leaves `ptr` unchanged.
- R5: With `push_dir`=1, `addr` equals `ptr` in the same cycle.
- R6: With `push_dir`=0, `addr` equals `ptr` minus one modulo 2^ADDR_W in the same cycle. At `ptr`=0 this gives all ones.
- R7: `empty` is 1 exactly when `ptr` is 0.
- R8: `full` is 1 exactly when `ptr` is 2^ADDR_W-1, which keeps the top slot in reserve.
- R9: A pop requested while `empty` is 1 leaves `ptr` at 0, and `fault` is 1 for the cycle after that edge.
- R10: A push requested while `full` is 1 leaves `ptr` unchanged, and `fault` is 1 for the cycle after that edge.
- R11: After an edge with no refused request (idle, or a legal push or pop), `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Asynchronous clear, active high |
| step_en | input | 1 | Commit a push or pop on this edge |
| push_dir | input | 1 | 1 = push, 0 = pop |
| ptr | output | ADDR_W | Current top-of-stack index |
| addr | output | ADDR_W | Memory address for the pending operation |
| empty | output | 1 | Index is 0 |
| full | output | 1 | Index is at the last usable value |
| fault | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench targets a pop from index 0. A design that lets the index wrap would show 15 and never flag the error. It also checks that the pop address at index 0 reads all ones and that the pop address is present before the edge. A block that registered the address, or decremented after reading, would show the pointer itself. A stack is filled to its reserved top and a further push is tried. A design off by one on the full threshold would step to the last slot or stop a slot early. Refused requests are issued back to back and then followed by a legal one, so a fault flag that sticks or never clears shows up. An asynchronous clear between edges catches a clear wired as synchronous.

// File: rtl/stack_addr_gen.sv
module stack_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              step_en,
  input  logic              push_dir,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] addr,
  output logic              empty,
  output logic              full,
  output logic              fault
);

  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic blocked;

  assign empty   = (ptr == '0);
  assign full    = (ptr == LAST);
  assign blocked = push_dir ? full : empty;
  assign addr    = push_dir ? ptr : ptr - ONE;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      ptr   <= '0;
      fault <= 1'b0;
    end else begin
      fault <= step_en & blocked;
      if (step_en && !blocked)
        ptr <= push_dir ? ptr + ONE : ptr - ONE;
    end
  end

  // R2
  a_r2_push_step: assert property (@(posedge clk) disable iff (clr)
    (step_en && push_dir && !full) |=> (ptr == $past(ptr) + ONE));
  // R3
  a_r3_pop_step: assert property (@(posedge clk) disable iff (clr)
    (step_en && !push_dir && !empty) |=> (ptr == $past(ptr) - ONE));
  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (clr)
    !step_en |=> $stable(ptr));
  // R9
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (clr)
    (step_en && !push_dir && empty) |=> (fault && ptr == '0));
  // R10
  a_r10_full_push: assert property (@(posedge clk) disable iff (clr)
    (step_en && push_dir && full) |=> (fault && ptr == LAST));
  // R11
  a_r11_fault_clear: assert property (@(posedge clk) disable iff (clr)
    (!step_en || (push_dir && !full) || (!push_dir && !empty)) |=> !fault);

endmodule

// File: tb/stack_addr_gen_test.sv
module stack_addr_gen_test;
  localparam int W = 4;

  logic clk = 0, clr = 1, step_en = 0, push_dir = 0;
  logic [W-1:0] ptr, addr;
  logic empty, full, fault;
  int checks = 0, errors = 0;
  logic [W-1:0] model;

  stack_addr_gen #(.ADDR_W(W)) uut (
    .clk(clk), .clr(clr), .step_en(step_en), .push_dir(push_dir),
    .ptr(ptr), .addr(addr), .empty(empty), .full(full), .fault(fault));

  always #10 clk = ~clk;

  // {en, dir, expected ptr after edge, expected fault after edge}
  localparam logic [6:0] VEC [0:11] = '{
    7'b10_0000_1, 7'b01_0000_0, 7'b11_0001_0, 7'b11_0010_0,
    7'b10_0001_0, 7'b00_0001_0, 7'b11_0010_0, 7'b10_0001_0,
    7'b10_0000_0, 7'b10_0000_1, 7'b10_0000_1, 7'b11_0001_0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pre_check();
    #1;
    chk(addr == (push_dir ? model : model - 4'd1), push_dir ? "R5" : "R6", addr,
        push_dir ? model : model - 4'd1);
    chk(empty == (model == 0), "R7", empty, model == 0);
    chk(full == (model == 4'hF), "R8", full, model == 4'hF);
  endtask

  task automatic step(input bit en, input bit dir, input bit exp_fault, input string req);
    @(negedge clk);
    step_en = en; push_dir = dir;
    pre_check();
    @(posedge clk);
    if (en && dir && model != 4'hF) model = model + 1;
    else if (en && !dir && model != 0) model = model - 1;
    #5;
    chk(ptr == model, req, ptr, model);
    chk(fault == exp_fault, exp_fault ? req : "R11", fault, exp_fault);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model = 0;
    #35;
    chk(ptr == 0, "R1", ptr, 0);
    chk(fault == 0, "R1", fault, 0);
    clr = 0;
    // vector table walk: R2 R3 R4 R9 R11
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      step_en = VEC[i][6]; push_dir = VEC[i][5];
      pre_check();
      @(posedge clk);
      model = VEC[i][4:1];
      #5;
      chk(ptr == VEC[i][4:1], "R2/R3/R4/R9 table", ptr, VEC[i][4:1]);
      chk(fault == VEC[i][0], "R9/R11 table", fault, VEC[i][0]);
    end
    // fill to the reserved top: R2, R8
    for (int i = 0; i < 14; i++) step(1, 1, 0, "R2");
    @(negedge clk); step_en = 0; push_dir = 1; #1;
    chk(full == 1, "R8", full, 1);
    chk(addr == 4'hF, "R5", addr, 15);
    // R10 push while full, twice, then idle
    step(1, 1, 1, "R10");
    step(1, 1, 1, "R10");
    step(0, 1, 0, "R11");
    // pop from full: R6 addr 14 then R3
    step(1, 0, 0, "R3");
    chk(ptr == 4'hE, "R3", ptr, 14);
    // R4 idle holds
    step(0, 0, 0, "R4");
    // R1 asynchronous clear between edges
    @(negedge clk); step_en = 0; #3; clr = 1; #1;
    chk(ptr == 0, "R1", ptr, 0);
    chk(fault == 0, "R1", fault, 0);
    model = 0;
    @(negedge clk); clr = 0;
    // R6 pop address at zero is all ones, and refused
    step(1, 0, 1, "R9");
    step(0, 0, 0, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule